// File: doc/BRIEF.md
# Disk DMA Chunk Sequencer

This block splits a single disk or packet-device data transfer into the pieces that a descriptor-driven DMA engine hands it, one piece at a time. A start command arms it with the device kind, the direction, a start sector or block address, and either a sector count (disk) or a byte size (packet device). The engine then kicks it with one memory address and one length per chunk. For each chunk the sequencer issues a storage request that carries the byte offset into the medium and the chunk length. When the storage side acknowledges, the sequencer tells the engine the chunk has ended.

The sequencer keeps a signed count of the bytes still owed and a running byte index. When a chunk request arrives and nothing is left to move, the transfer completes: the status becomes ready with seek complete, the interrupt is raised and the sequencer disarms. Two other paths exist. A packet-device transfer whose block address is all ones is a plain buffer copy, clipped to the chunk length. A storage error aborts the transfer with an error status. A chunk request that arrives while the sequencer is disarmed is handed back unconsumed, and the engine must retry it after the next start.

Top module: `dcs_top`

## Requirements
- R1: After reset `active`, `irq`, `xfer_err`, `st_req`, `chunk_done`, `chunk_parked` and `xfer_done` are 0 and `status` is 0x00.
- R2: An accepted start sets `active`, clears the running index, and loads the remaining byte count with `start_sectors`×512 for a disk (`start_optical`=0) or with `start_pkt_bytes` for a packet device (`start_optical`=1).
- R3: A `chunk_valid` pulse while `active` is 0, or in the same cycle as an accepted start, gives a one-cycle `chunk_parked` in the next cycle. It gives no `st_req` and no `chunk_done`, and it leaves the index and remaining count unchanged.
- R4: For a block chunk, `st_req` rises in the cycle after `chunk_valid`. It carries `st_offset` = (`start_block`<<9 for a disk, <<11 for a packet device) + running index, `st_len` = `chunk_len`, `st_addr` = `chunk_addr`, `st_write` = `start_write` and `st_copy`=0.
- R5: After a block chunk is issued, the remaining count drops by its length and the index grows by its length. `chunk_done` pulses in the cycle after `st_ack` is sampled.
- R6: A chunk request that finds the remaining count zero or negative issues no storage request. In the next cycle it gives `chunk_done` and `xfer_done`, `status`=0x50 and `irq`=1, and it clears `active`. This includes the case where the last chunk overran the count.
- R7: A zero-length chunk while bytes remain gives only `chunk_done` and leaves the index and remaining count unchanged.
- R8: For a packet device with `start_block` all ones, a chunk issues `st_req` with `st_copy`=1, `st_offset`=0 and `st_len` = min(remaining, `chunk_len`). Its acknowledge completes the transfer with `chunk_done`, `xfer_done`, `status`=0x50 and `irq`=1, and it clears `active`.
- R9: `st_ack` with `st_err`=1 gives `chunk_done` and `xfer_done`, `status`=0x51, `xfer_err`=1 and `irq`=1, and it clears `active`.
- R10: `st_req` is high for exactly one cycle. Any number of cycles may pass before `st_ack`, and no new chunk is taken until it arrives.
- R11: A start pulse while a storage acknowledge is pending is ignored, and the transfer in flight continues at its own offset.
- R12: An accepted start clears `irq`, `xfer_err` and `status` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start command pulse |
| start_optical | input | 1 | 1 = packet device, 0 = disk |
| start_write | input | 1 | 1 = memory to storage |
| start_sectors | input | SEC_W | Disk sector count |
| start_block | input | BLK_W | Start sector (disk) or block address (packet) |
| start_pkt_bytes | input | REM_W | Packet transfer size in bytes |
| chunk_valid | input | 1 | Chunk request pulse from the DMA engine |
| chunk_addr | input | ADDR_W | Memory address of the chunk |
| chunk_len | input | LEN_W | Chunk length in bytes |
| chunk_done | output | 1 | End-of-chunk acknowledge to the engine |
| chunk_parked | output | 1 | Chunk refused, channel idle |
| st_req | output | 1 | Storage request pulse |
| st_write | output | 1 | Storage request direction |
| st_copy | output | 1 | Request is a non-block buffer copy |
| st_addr | output | ADDR_W | Memory address for the request |
| st_offset | output | OFS_W | Storage byte offset |
| st_len | output | LEN_W | Request length in bytes |
| st_ack | input | 1 | Storage acknowledge |
| st_err | input | 1 | Storage error, valid with st_ack |
| active | output | 1 | Transfer armed |
| xfer_done | output | 1 | Transfer completion pulse |
| xfer_err | output | 1 | Transfer ended in error |
| status | output | 8 | Device status byte |
| irq | output | 1 | Device interrupt level |

## Verification
On every cycle the assertions check the following. The storage request is a single-cycle pulse. Refusal and end-of-chunk never coincide, and a refusal only follows a disarmed cycle or a start. Disarming always comes with a completion pulse. The status byte on a completion matches its outcome. Between starts, the sum of the remaining count and the index never changes. Only the bench's scenarios can show the arithmetic: the two offset shifts and the remaining count that picks the chunk on which the transfer completes, including an overrun. They also cover the clipped copy length, the refused chunk being retried after a start, a start ignored in flight, and acknowledges arriving after varying delays.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} dcs_state_e;

  typedef enum logic [2:0] {
    ACT_PARK,
    ACT_FINISH,
    ACT_SKIP,
    ACT_COPY,
    ACT_BLOCK
  } dcs_action_e;

  localparam logic [7:0] STS_OK  = 8'h50;
  localparam logic [7:0] STS_ERR = 8'h51;
endpackage

// File: rtl/dcs_tracker.sv
module dcs_tracker #(
  parameter int SEC_W      = 8,
  parameter int BLK_W      = 32,
  parameter int REM_W      = 32,
  parameter int LEN_W      = 16,
  parameter int OFS_W      = 64,
  parameter int DISK_SHIFT = 9,
  parameter int OPT_SHIFT  = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    ld_optical,
  input  logic                    ld_write,
  input  logic [SEC_W-1:0]        ld_sectors,
  input  logic [BLK_W-1:0]        ld_block,
  input  logic [REM_W-1:0]        ld_pkt_bytes,
  input  logic                    adv,
  input  logic [LEN_W-1:0]        adv_len,
  input  logic [LEN_W-1:0]        req_len,
  output logic signed [REM_W-1:0] remaining,
  output logic [OFS_W-1:0]        offset,
  output logic [LEN_W-1:0]        clip_len,
  output logic                    nonblock,
  output logic                    write_mode
);
  localparam int IDX_W = REM_W;

  logic signed [REM_W-1:0] rem_q;
  logic [IDX_W-1:0]        idx_q;
  logic [OFS_W-1:0]        base_q;
  logic                    nb_q;
  logic                    wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      idx_q  <= '0;
      base_q <= '0;
      nb_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else if (load) begin
      idx_q <= '0;
      wr_q  <= ld_write;
      nb_q  <= ld_optical && (&ld_block);
      if (ld_optical) begin
        rem_q  <= $signed(ld_pkt_bytes);
        base_q <= OFS_W'(ld_block) << OPT_SHIFT;
      end else begin
        rem_q  <= $signed(REM_W'(ld_sectors) << DISK_SHIFT);
        base_q <= OFS_W'(ld_block) << DISK_SHIFT;
      end
    end else if (adv) begin
      rem_q <= rem_q - $signed(REM_W'(adv_len));
      idx_q <= idx_q + IDX_W'(adv_len);
    end
  end

  always_comb begin
    offset     = base_q + OFS_W'(idx_q);
    remaining  = rem_q;
    nonblock   = nb_q;
    write_mode = wr_q;
    if ($unsigned(rem_q) < REM_W'(req_len)) clip_len = rem_q[LEN_W-1:0];
    else                                    clip_len = req_len;
  end

  // Bytes owed plus bytes moved is fixed for the life of one transfer.
  logic [REM_W-1:0] ledger;
  assign ledger = $unsigned(rem_q) + REM_W'(idx_q);

  assert_ledger_constant_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> ledger == $past(ledger));
endmodule

// File: rtl/dcs_classify.sv
module dcs_classify import dcs_pkg::*; #(
  parameter int REM_W = 32,
  parameter int LEN_W = 16
) (
  input  logic                    active,
  input  logic signed [REM_W-1:0] remaining,
  input  logic [LEN_W-1:0]        len,
  input  logic                    nonblock,
  output dcs_action_e             action
);
  logic exhausted;
  assign exhausted = remaining[REM_W-1] || (remaining == '0);

  always_comb begin
    if (!active)           action = ACT_PARK;
    else if (exhausted)    action = ACT_FINISH;
    else if (len == '0)    action = ACT_SKIP;
    else if (nonblock)     action = ACT_COPY;
    else                   action = ACT_BLOCK;
  end
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl import dcs_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int OFS_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic              chunk_valid,
  input  logic [ADDR_W-1:0] chunk_addr,
  input  logic [LEN_W-1:0]  chunk_len,
  input  dcs_action_e       action,
  input  logic [LEN_W-1:0]  clip_len,
  input  logic [OFS_W-1:0]  chunk_offset,
  input  logic              write_mode,
  input  logic              st_ack,
  input  logic              st_err,
  output logic              load,
  output logic              adv,
  output logic              active,
  output logic              chunk_done,
  output logic              chunk_parked,
  output logic              st_req,
  output logic              st_write,
  output logic              st_copy,
  output logic [ADDR_W-1:0] st_addr,
  output logic [OFS_W-1:0]  st_offset,
  output logic [LEN_W-1:0]  st_len,
  output logic              xfer_done,
  output logic              xfer_err,
  output logic [7:0]        status,
  output logic              irq
);
  dcs_state_e state_q;
  logic       pend_copy_q;

  assign load = (state_q == ST_IDLE) && start_valid;
  assign adv  = (state_q == ST_IDLE) && !start_valid && chunk_valid && (action == ACT_BLOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pend_copy_q  <= 1'b0;
      active       <= 1'b0;
      chunk_done   <= 1'b0;
      chunk_parked <= 1'b0;
      st_req       <= 1'b0;
      st_write     <= 1'b0;
      st_copy      <= 1'b0;
      st_addr      <= '0;
      st_offset    <= '0;
      st_len       <= '0;
      xfer_done    <= 1'b0;
      xfer_err     <= 1'b0;
      status       <= 8'h00;
      irq          <= 1'b0;
    end else begin
      chunk_done   <= 1'b0;
      chunk_parked <= 1'b0;
      st_req       <= 1'b0;
      xfer_done    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_valid) begin
            active   <= 1'b1;
            irq      <= 1'b0;
            xfer_err <= 1'b0;
            status   <= 8'h00;
            if (chunk_valid) chunk_parked <= 1'b1;
          end else if (chunk_valid) begin
            case (action)
              ACT_PARK: chunk_parked <= 1'b1;
              ACT_FINISH: begin
                chunk_done <= 1'b1;
                xfer_done  <= 1'b1;
                status     <= STS_OK;
                irq        <= 1'b1;
                active     <= 1'b0;
              end
              ACT_SKIP: chunk_done <= 1'b1;
              ACT_COPY: begin
                st_req      <= 1'b1;
                st_copy     <= 1'b1;
                st_write    <= 1'b0;
                st_addr     <= chunk_addr;
                st_offset   <= '0;
                st_len      <= clip_len;
                pend_copy_q <= 1'b1;
                state_q     <= ST_WAIT;
              end
              default: begin
                st_req      <= 1'b1;
                st_copy     <= 1'b0;
                st_write    <= write_mode;
                st_addr     <= chunk_addr;
                st_offset   <= chunk_offset;
                st_len      <= chunk_len;
                pend_copy_q <= 1'b0;
                state_q     <= ST_WAIT;
              end
            endcase
          end
        end
        default: begin
          if (st_ack) begin
            chunk_done <= 1'b1;
            state_q    <= ST_IDLE;
            if (st_err) begin
              xfer_done <= 1'b1;
              xfer_err  <= 1'b1;
              status    <= STS_ERR;
              irq       <= 1'b1;
              active    <= 1'b0;
            end else if (pend_copy_q) begin
              xfer_done <= 1'b1;
              status    <= STS_OK;
              irq       <= 1'b1;
              active    <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  assert_req_single_R10: assert property (@(posedge clk) disable iff (rst)
    st_req |=> !st_req);
  assert_park_when_disarmed_R3: assert property (@(posedge clk) disable iff (rst)
    chunk_parked |-> ($past(!active) || $past(start_valid)));
  assert_park_done_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(chunk_parked && chunk_done));
  assert_disarm_completes_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (xfer_done && irq));
  assert_ok_status_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !xfer_err) |-> status == STS_OK);
  assert_err_status_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_err |-> (status == STS_ERR && irq));
endmodule

// File: rtl/dcs_top.sv
module dcs_top import dcs_pkg::*; #(
  parameter int SEC_W      = 8,
  parameter int BLK_W      = 32,
  parameter int REM_W      = 32,
  parameter int LEN_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 64,
  parameter int DISK_SHIFT = 9,
  parameter int OPT_SHIFT  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_valid,
  input  logic              start_optical,
  input  logic              start_write,
  input  logic [SEC_W-1:0]  start_sectors,
  input  logic [BLK_W-1:0]  start_block,
  input  logic [REM_W-1:0]  start_pkt_bytes,
  input  logic              chunk_valid,
  input  logic [ADDR_W-1:0] chunk_addr,
  input  logic [LEN_W-1:0]  chunk_len,
  output logic              chunk_done,
  output logic              chunk_parked,
  output logic              st_req,
  output logic              st_write,
  output logic              st_copy,
  output logic [ADDR_W-1:0] st_addr,
  output logic [OFS_W-1:0]  st_offset,
  output logic [LEN_W-1:0]  st_len,
  input  logic              st_ack,
  input  logic              st_err,
  output logic              active,
  output logic              xfer_done,
  output logic              xfer_err,
  output logic [7:0]        status,
  output logic              irq
);
  logic                    load, adv, nonblock, write_mode;
  logic signed [REM_W-1:0] remaining;
  logic [OFS_W-1:0]        offset;
  logic [LEN_W-1:0]        clip_len;
  dcs_action_e             action;

  dcs_tracker #(
    .SEC_W(SEC_W), .BLK_W(BLK_W), .REM_W(REM_W), .LEN_W(LEN_W),
    .OFS_W(OFS_W), .DISK_SHIFT(DISK_SHIFT), .OPT_SHIFT(OPT_SHIFT)
  ) u_tracker (
    .clk(clk), .rst(rst), .load(load), .ld_optical(start_optical),
    .ld_write(start_write), .ld_sectors(start_sectors), .ld_block(start_block),
    .ld_pkt_bytes(start_pkt_bytes), .adv(adv), .adv_len(chunk_len),
    .req_len(chunk_len), .remaining(remaining), .offset(offset),
    .clip_len(clip_len), .nonblock(nonblock), .write_mode(write_mode)
  );

  dcs_classify #(.REM_W(REM_W), .LEN_W(LEN_W)) u_classify (
    .active(active), .remaining(remaining), .len(chunk_len),
    .nonblock(nonblock), .action(action)
  );

  dcs_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFS_W(OFS_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_valid(start_valid), .chunk_valid(chunk_valid),
    .chunk_addr(chunk_addr), .chunk_len(chunk_len), .action(action),
    .clip_len(clip_len), .chunk_offset(offset), .write_mode(write_mode),
    .st_ack(st_ack), .st_err(st_err), .load(load), .adv(adv), .active(active),
    .chunk_done(chunk_done), .chunk_parked(chunk_parked), .st_req(st_req),
    .st_write(st_write), .st_copy(st_copy), .st_addr(st_addr),
    .st_offset(st_offset), .st_len(st_len), .xfer_done(xfer_done),
    .xfer_err(xfer_err), .status(status), .irq(irq)
  );
endmodule

// File: tb/tb_dcs_top.sv
module tb_dcs_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_valid = 1'b0, start_optical = 1'b0, start_write = 1'b0;
  logic [7:0]  start_sectors = '0;
  logic [31:0] start_block = '0, start_pkt_bytes = '0;
  logic        chunk_valid = 1'b0;
  logic [31:0] chunk_addr = '0;
  logic [15:0] chunk_len = '0;
  logic        st_ack = 1'b0, st_err = 1'b0;
  logic        chunk_done, chunk_parked, st_req, st_write, st_copy;
  logic [31:0] st_addr;
  logic [63:0] st_offset;
  logic [15:0] st_len;
  logic        active, xfer_done, xfer_err, irq;
  logic [7:0]  status;

  int n_tests = 0, n_fail = 0;

  // observations of the last chunk
  logic        o_req, o_park, o_copy, o_wr, o_cdone, o_xdone, o_pulse_bad;
  logic [63:0] o_off;
  logic [15:0] o_len;
  logic [31:0] o_addr;

  dcs_top dut (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_optical(start_optical),
    .start_write(start_write), .start_sectors(start_sectors), .start_block(start_block),
    .start_pkt_bytes(start_pkt_bytes), .chunk_valid(chunk_valid), .chunk_addr(chunk_addr),
    .chunk_len(chunk_len), .chunk_done(chunk_done), .chunk_parked(chunk_parked),
    .st_req(st_req), .st_write(st_write), .st_copy(st_copy), .st_addr(st_addr),
    .st_offset(st_offset), .st_len(st_len), .st_ack(st_ack), .st_err(st_err),
    .active(active), .xfer_done(xfer_done), .xfer_err(xfer_err), .status(status), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_start(input bit opt, input bit wr, input int sec, input int blk, input int pkt);
    @(negedge clk);
    start_valid = 1'b1; start_optical = opt; start_write = wr;
    start_sectors = 8'(sec); start_block = 32'(blk); start_pkt_bytes = 32'(pkt);
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic do_chunk(input int addr, input int len, input int lat, input bit err, input bit mid_start);
    @(negedge clk);
    chunk_valid = 1'b1; chunk_addr = 32'(addr); chunk_len = 16'(len);
    @(negedge clk);
    chunk_valid = 1'b0;
    o_req = st_req; o_park = chunk_parked; o_copy = st_copy; o_wr = st_write;
    o_off = st_offset; o_len = st_len; o_addr = st_addr;
    o_cdone = chunk_done; o_xdone = xfer_done; o_pulse_bad = 1'b0;
    if (st_req) begin
      for (int i = 0; i < lat; i++) begin
        if (mid_start && i == 0) begin
          start_valid = 1'b1; start_optical = 1'b1; start_block = 32'h77;
          start_pkt_bytes = 32'd4;
        end
        @(negedge clk);
        start_valid = 1'b0;
        if (st_req || chunk_done) o_pulse_bad = 1'b1;
      end
      st_ack = 1'b1; st_err = err;
      @(negedge clk);
      st_ack = 1'b0; st_err = 1'b0;
      o_cdone = chunk_done; o_xdone = xfer_done;
    end
  endtask

  task automatic run_sweep(input bit opt, input bit wr, input int sec, input int blk,
                           input int pkt, input int len, input int latbase);
    longint base, idx;
    int rem;
    do_start(opt, wr, sec, blk, pkt);
    chk("R2", "active after start", 64'(active), 64'd1);
    base = opt ? (longint'(blk) << 11) : (longint'(blk) << 9);
    rem = opt ? pkt : sec * 512;
    idx = 0;
    for (int k = 0; k < 40; k++) begin
      do_chunk(32'h1000 + k * 16, len, (k + latbase) % 4, 1'b0, 1'b0);
      if (rem <= 0) begin
        chk("R6", "no req at end", 64'(o_req), 64'd0);
        chk("R6", "end done", 64'({o_cdone, o_xdone}), 64'd3);
        chk("R6", "status", 64'(status), 64'h50);
        chk("R6", "irq/active", 64'({irq, active}), 64'b10);
        break;
      end
      chk("R4", "req", 64'(o_req), 64'd1);
      chk("R4", "offset", o_off, 64'(base + idx));
      chk("R4", "len/copy/wr", 64'({o_len, o_copy, o_wr}), 64'({16'(len), 1'b0, wr}));
      chk("R4", "addr", 64'(o_addr), 64'(32'h1000 + k * 16));
      chk("R10", "pulse/latency", 64'(o_pulse_bad), 64'd0);
      chk("R5", "chunk done", 64'({o_cdone, o_xdone}), 64'b10);
      rem = rem - len;
      idx = idx + len;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset outputs", 64'({active, irq, xfer_err, st_req, chunk_done, chunk_parked, xfer_done}), 64'd0);
    chk("R1", "reset status", 64'(status), 64'h00);

    // R3: chunk before any start is parked
    do_chunk(32'h40, 512, 0, 1'b0, 1'b0);
    chk("R3", "parked", 64'({o_park, o_req, o_cdone}), 64'b100);
    do_start(1'b0, 1'b0, 2, 3, 0);
    do_chunk(32'h40, 512, 1, 1'b0, 1'b0);
    chk("R3", "index untouched after park", o_off, 64'(3 << 9));

    // R3: start and chunk in the same cycle
    @(negedge clk);
    start_valid = 1'b1; start_optical = 1'b0; start_sectors = 8'd1; start_block = 32'd9;
    chunk_valid = 1'b1; chunk_len = 16'd512;
    @(negedge clk);
    start_valid = 1'b0; chunk_valid = 1'b0;
    chk("R3", "park with start", 64'({chunk_parked, st_req, chunk_done}), 64'b100);

    // R7: zero-length chunk
    do_start(1'b0, 1'b1, 2, 5, 0);
    do_chunk(32'h80, 0, 0, 1'b0, 1'b0);
    chk("R7", "zero len", 64'({o_req, o_cdone, o_xdone}), 64'b010);
    do_chunk(32'h80, 512, 2, 1'b0, 1'b0);
    chk("R7", "offset after zero len", o_off, 64'(5 << 9));

    // R8: non-block packet copy clipped to remaining
    do_start(1'b1, 1'b0, 0, 32'hFFFF_FFFF, 100);
    do_chunk(32'h200, 512, 1, 1'b0, 1'b0);
    chk("R8", "copy req", 64'({o_req, o_copy}), 64'b11);
    chk("R8", "copy len clipped", 64'(o_len), 64'd100);
    chk("R8", "copy offset", o_off, 64'd0);
    chk("R8", "copy completes", 64'({o_cdone, o_xdone, irq, active}), 64'b1110);
    chk("R8", "copy status", 64'(status), 64'h50);
    do_start(1'b1, 1'b0, 0, 32'hFFFF_FFFF, 1000);
    do_chunk(32'h200, 300, 0, 1'b0, 1'b0);
    chk("R8", "copy len chunk", 64'(o_len), 64'd300);

    // R3: chunk after completion is parked
    do_chunk(32'h200, 300, 0, 1'b0, 1'b0);
    chk("R3", "parked after end", 64'({o_park, o_req}), 64'b10);

    // R9: storage error
    do_start(1'b0, 1'b0, 2, 1, 0);
    do_chunk(32'h300, 512, 3, 1'b1, 1'b0);
    chk("R9", "error end", 64'({o_cdone, o_xdone, xfer_err, irq, active}), 64'b11110);
    chk("R9", "error status", 64'(status), 64'h51);

    // R12: start clears irq/err/status
    do_start(1'b0, 1'b0, 4, 10, 0);
    chk("R12", "cleared", 64'({irq, xfer_err, status}), 64'd0);

    // R11: start ignored while waiting for ack
    do_chunk(32'h400, 512, 2, 1'b0, 1'b1);
    do_chunk(32'h400, 512, 0, 1'b0, 1'b0);
    chk("R11", "offset continues", o_off, 64'(10 * 512 + 512));
    chk("R11", "still disk write mode", 64'(o_copy), 64'd0);

    // sweeps: disk and packet, several chunk sizes and latencies
    for (int sec = 1; sec <= 3; sec++) begin
      run_sweep(1'b0, sec[0], sec, 100 * sec, 0, 200, sec);
      run_sweep(1'b0, ~sec[0], sec, 7 + sec, 0, 512, 0);
      run_sweep(1'b0, 1'b1, sec, 33, 0, 1000, 2);
      run_sweep(1'b1, sec[0], 0, 3 + sec, sec * 700, 512, 1);
      run_sweep(1'b1, 1'b0, 0, 20 * sec, sec * 700, 1000, 3);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule